// File: doc/BRIEF.md
# Sixteen-entry content addressable key memory

This block is a small content addressable memory. It has sixteen entries, and each entry holds one 8-bit key. Keys are written by address. A search presents a key and returns a vector with one bit for each entry. A bit is set when that entry holds the key, so one search can report several entries at once.

A write takes two cycles, both with the write enable high. The first cycle strobes `store_i` and carries the new key and the target address. The second cycle strobes `erase_i`. That second cycle commits the write: it removes the key the entry held before and makes the new key searchable. The key bus is ignored on the commit cycle.

The search result sits in a register. It is loaded only when the search enable is high and is held otherwise. A synchronous active-low clear forces it to zero.

Top module: `cam_match_array`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `match_o` is zero and no entry matches any key, including key 0x00.
- R2: With `srch_en_i` high, `match_o` bit i is set in the next cycle exactly when entry i holds `key_i`.
- R3: A key held by several entries sets all of their bits together (key at entries 5, 7 and 12 gives 0x10A0).
- R4: A search for a key held by no entry loads an all-zero vector.
- R5: A write becomes searchable only after its commit cycle. A search issued in the store cycle or in the commit cycle sees the contents as they were before the write.
- R6: Overwriting an entry removes its old key: that entry's bit drops for the old key and rises for the new key.
- R7: On the commit cycle, the value on `key_i` has no effect on the stored key. The key latched in the store cycle is the one written.
- R8: With `srch_en_i` low and `mclr_ni` high, `match_o` keeps its value, including during write cycles.
- R9: `mclr_ni` low at a clock edge clears `match_o` to zero, whatever `srch_en_i` is.
- R10: Rewriting the key an entry already holds leaves that entry matching the key.
- R11: A commit strobe with no preceding store, or any strobe with `wr_en_i` low, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_i | input | 8 | Key to write (store cycle) or to search |
| addr_i | input | 4 | Entry address for the store cycle |
| wr_en_i | input | 1 | Write enable; must be high for both write cycles |
| store_i | input | 1 | Store strobe (first write cycle) |
| erase_i | input | 1 | Commit strobe (second write cycle) |
| srch_en_i | input | 1 | Load the match register with the search result |
| mclr_ni | input | 1 | Synchronous active-low clear of the match register |
| match_o | output | 16 | Registered match vector, one bit per entry |

## Verification
A wrong entry in the key map or in an entry's shadow key shows up as a missing bit or an extra bit in `match_o`. It appears one cycle after the first search for the affected key.

A stale shadow key is only exposed when that entry is overwritten. The old key then keeps matching, so the bench searches both old and new keys after every overwrite. Write ordering faults appear on searches issued during the store and commit cycles. Faults in the hold and clear logic appear on the first cycle with search disabled or with the clear low.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned KEY_W_DEF = 8;
  localparam int unsigned N_ENT_DEF = 16;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_COMMIT = 2'd2
  } wr_op_e;

  // store wins if both strobes are high
  function automatic wr_op_e decode_op(input logic wr_en, input logic store, input logic erase);
    if (!wr_en)     return OP_IDLE;
    else if (store) return OP_STORE;
    else if (erase) return OP_COMMIT;
    else            return OP_IDLE;
  endfunction
endpackage

// File: rtl/cam_wr_ctrl.sv
module cam_wr_ctrl
  import cam_pkg::*;
#(
  parameter int unsigned KEY_W  = KEY_W_DEF,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              store_i,
  input  logic              erase_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              commit_o,
  output logic [KEY_W-1:0]  cm_key_o,
  output logic [ADDR_W-1:0] cm_addr_o
);
  wr_op_e            op;
  logic              pend_q;
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] addr_q;

  assign op = decode_op(wr_en_i, store_i, erase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      key_q  <= '0;
      addr_q <= '0;
    end else begin
      case (op)
        OP_STORE: begin
          pend_q <= 1'b1;
          key_q  <= key_i;
          addr_q <= addr_i;
        end
        OP_COMMIT: pend_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign commit_o  = (op == OP_COMMIT) && pend_q;
  assign cm_key_o  = key_q;
  assign cm_addr_o = addr_q;
endmodule

// File: rtl/cam_shadow.sv
module cam_shadow #(
  parameter int unsigned KEY_W  = 8,
  parameter int unsigned N_ENT  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         commit_i,
  input  logic [KEY_W-1:0]             cm_key_i,
  input  logic [ADDR_W-1:0]            cm_addr_i,
  output logic [KEY_W-1:0]             old_key_o,
  output logic                         old_vld_o,
  output logic [N_ENT-1:0][KEY_W-1:0]  sh_key_o,
  output logic [N_ENT-1:0]             sh_vld_o
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic hit;
    assign hit = commit_i && (cm_addr_i == ADDR_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_key_o[e] <= '0;
        sh_vld_o[e] <= 1'b0;
      end else if (hit) begin
        sh_key_o[e] <= cm_key_i;
        sh_vld_o[e] <= 1'b1;
      end
    end
  end

  assign old_key_o = sh_key_o[cm_addr_i];
  assign old_vld_o = sh_vld_o[cm_addr_i];
endmodule

// File: rtl/cam_keymap.sv
module cam_keymap #(
  parameter int unsigned KEY_W  = 8,
  parameter int unsigned N_ENT  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [KEY_W-1:0]  new_key_i,
  input  logic [KEY_W-1:0]  old_key_i,
  input  logic              old_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  srch_key_i,
  output logic [N_ENT-1:0]  row_o
);
  localparam int unsigned N_KEY = 1 << KEY_W;

  logic [N_ENT-1:0] map_q [N_KEY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_KEY; k++) map_q[k] <= '0;
    end else if (commit_i) begin
      if (old_vld_i) map_q[old_key_i][addr_i] <= 1'b0;
      // set after clear: same-key rewrite keeps the bit
      map_q[new_key_i][addr_i] <= 1'b1;
    end
  end

  assign row_o = map_q[srch_key_i];
endmodule

// File: rtl/cam_match_reg.sv
module cam_match_reg #(
  parameter int unsigned N_ENT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srch_en_i,
  input  logic             mclr_ni,
  input  logic [N_ENT-1:0] row_i,
  output logic [N_ENT-1:0] match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        match_o <= '0;
    else if (!mclr_ni)  match_o <= '0;
    else if (srch_en_i) match_o <= row_i;
  end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array
  import cam_pkg::*;
#(
  parameter int unsigned KEY_W = KEY_W_DEF,
  parameter int unsigned N_ENT = N_ENT_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [KEY_W-1:0]         key_i,
  input  logic [$clog2(N_ENT)-1:0] addr_i,
  input  logic                     wr_en_i,
  input  logic                     store_i,
  input  logic                     erase_i,
  input  logic                     srch_en_i,
  input  logic                     mclr_ni,
  output logic [N_ENT-1:0]         match_o
);
  localparam int unsigned ADDR_W = $clog2(N_ENT);

  logic                        commit;
  logic [KEY_W-1:0]            cm_key;
  logic [ADDR_W-1:0]           cm_addr;
  logic [KEY_W-1:0]            old_key;
  logic                        old_vld;
  logic [N_ENT-1:0][KEY_W-1:0] sh_key;
  logic [N_ENT-1:0]            sh_vld;
  logic [N_ENT-1:0]            row;

  cam_wr_ctrl #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .wr_en_i, .store_i, .erase_i, .key_i, .addr_i,
    .commit_o(commit), .cm_key_o(cm_key), .cm_addr_o(cm_addr)
  );

  cam_shadow #(.KEY_W(KEY_W), .N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_sh (
    .clk_i, .rst_ni, .commit_i(commit), .cm_key_i(cm_key), .cm_addr_i(cm_addr),
    .old_key_o(old_key), .old_vld_o(old_vld), .sh_key_o(sh_key), .sh_vld_o(sh_vld)
  );

  cam_keymap #(.KEY_W(KEY_W), .N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_map (
    .clk_i, .rst_ni, .commit_i(commit), .new_key_i(cm_key), .old_key_i(old_key),
    .old_vld_i(old_vld), .addr_i(cm_addr), .srch_key_i(key_i), .row_o(row)
  );

  cam_match_reg #(.N_ENT(N_ENT)) u_mr (
    .clk_i, .rst_ni, .srch_en_i, .mclr_ni, .row_i(row), .match_o
  );
endmodule

// File: rtl/cam_match_chk.sv
module cam_match_chk #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned N_ENT = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic                        store_i,
  input logic                        erase_i,
  input logic                        srch_en_i,
  input logic                        mclr_ni,
  input logic [N_ENT-1:0]            match_o,
  input logic                        commit,
  input logic [KEY_W-1:0]            cm_key,
  input logic [$clog2(N_ENT)-1:0]    cm_addr,
  input logic [N_ENT-1:0][KEY_W-1:0] sh_key,
  input logic [N_ENT-1:0]            sh_vld
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (match_o == '0);
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srch_en_i && mclr_ni) |=> $stable(match_o));

  assert_sync_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclr_ni |=> (match_o == '0));

  assert_commit_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (sh_vld[$past(cm_addr)] && sh_key[$past(cm_addr)] == $past(cm_key)));

  assert_no_stray_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && erase_i && !store_i) |=> ($stable(sh_key) && $stable(sh_vld)));
endmodule

bind cam_match_array cam_match_chk #(.KEY_W(KEY_W), .N_ENT(N_ENT)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .store_i, .erase_i, .srch_en_i, .mclr_ni, .match_o,
  .commit, .cm_key, .cm_addr, .sh_key, .sh_vld
);

// File: tb/cam_match_array_tb.sv
`timescale 1ns/1ps
module cam_match_array_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  key = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, store = 1'b0, erase = 1'b0, srch_en = 1'b0, mclr_n = 1'b1;
  logic [15:0] match;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_key [16];
  logic        m_vld [16];
  logic        m_pend = 1'b0;
  logic [7:0]  m_pkey = '0;
  logic [3:0]  m_paddr = '0;
  logic [15:0] m_match = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_match_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .addr_i(addr), .wr_en_i(wr_en),
    .store_i(store), .erase_i(erase), .srch_en_i(srch_en), .mclr_ni(mclr_n),
    .match_o(match)
  );

  function automatic logic [15:0] exp_row(input logic [7:0] k);
    logic [15:0] r = '0;
    for (int e = 0; e < 16; e++) if (m_vld[e] && m_key[e] == k) r[e] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (match !== exp) begin
      errors++;
      $display("FAIL %s: match=%h expected=%h at %0t", tag, match, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, update model at posedge, check after it
  task automatic cyc(input string tag, input logic [7:0] k, input logic [3:0] a,
                     input logic we, input logic st, input logic er,
                     input logic se, input logic mc);
    key = k; addr = a; wr_en = we; store = st; erase = er; srch_en = se; mclr_n = mc;
    @(posedge clk);
    if (!mc)      m_match = '0;
    else if (se)  m_match = exp_row(k);
    if (we && st) begin
      m_pend = 1'b1; m_pkey = k; m_paddr = a;
    end else if (we && er) begin
      if (m_pend) begin m_key[m_paddr] = m_pkey; m_vld[m_paddr] = 1'b1; end
      m_pend = 1'b0;
    end
    #1;
    check(tag, m_match);
    @(negedge clk);
  endtask

  task automatic write(input string tag, input logic [7:0] k, input logic [3:0] a,
                       input logic [7:0] junk, input logic se);
    cyc(tag, k, a, 1, 1, 0, se, 1);
    cyc(tag, junk, a, 1, 0, 1, se, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < 16; e++) begin m_key[e] = '0; m_vld[e] = 1'b0; end
    repeat (3) @(negedge clk);
    #1; check("R1 reset", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1 unwritten key 00", 8'h00, 0, 0, 0, 0, 1, 1);
    check("R1 explicit zero", 16'h0000);
    // R5: search during store and commit cycles sees old contents; R7 junk ignored
    cyc("R5 store-cycle search", 8'h01, 4'h2, 1, 1, 0, 1, 1);
    check("R5 store-cycle zero", 16'h0000);
    cyc("R5 commit-cycle search", 8'h01, 4'h2, 1, 0, 1, 1, 1);
    check("R5 commit-cycle zero", 16'h0000);
    cyc("R2 single match", 8'h01, 0, 0, 0, 0, 1, 1);
    check("R2 bit 2", 16'h0004);
    write("R7 write", 8'h69, 4'h9, 8'h55, 0);
    cyc("R7 junk key absent", 8'h55, 0, 0, 0, 0, 1, 1);
    check("R7 zero", 16'h0000);
    cyc("R7 latched key", 8'h69, 0, 0, 0, 0, 1, 1);
    check("R7 bit 9", 16'h0200);
    // R3 multi-match
    write("R3 w5", 8'hC2, 4'h5, 8'h00, 0);
    write("R3 w7", 8'hC2, 4'h7, 8'h11, 0);
    write("R3 w12", 8'hC2, 4'hC, 8'h22, 0);
    cyc("R3 multi", 8'hC2, 0, 0, 0, 0, 1, 1);
    check("R3 10A0", 16'h10A0);
    cyc("R4 missing", 8'h61, 0, 0, 0, 0, 1, 1);
    check("R4 zero", 16'h0000);
    // R8 hold, including during a write
    cyc("R3 reload", 8'hC2, 0, 0, 0, 0, 1, 1);
    cyc("R8 idle hold", 8'h01, 0, 0, 0, 0, 0, 1);
    write("R8 hold in write", 8'hFF, 4'h2, 8'hFF, 0);
    check("R8 still 10A0", 16'h10A0);
    // R6 overwrite of entry 2 (was 01, now FF)
    cyc("R6 old key gone", 8'h01, 0, 0, 0, 0, 1, 1);
    check("R6 zero", 16'h0000);
    cyc("R6 new key", 8'hFF, 0, 0, 0, 0, 1, 1);
    check("R6 bit 2", 16'h0004);
    // R9 clear beats search enable
    cyc("R9 clear with search", 8'hFF, 0, 0, 0, 0, 1, 0);
    check("R9 zero", 16'h0000);
    cyc("R8 hold after clear", 8'hFF, 0, 0, 0, 0, 0, 1);
    // R10 same-key rewrite
    write("R10 rewrite", 8'hFF, 4'h2, 8'h00, 0);
    cyc("R10 still matches", 8'hFF, 0, 0, 0, 0, 1, 1);
    check("R10 bit 2", 16'h0004);
    // R11 stray strobes
    cyc("R11 lone erase", 8'h77, 4'h3, 1, 0, 1, 0, 1);
    cyc("R11 store wr_en low", 8'h77, 4'h3, 0, 1, 0, 0, 1);
    cyc("R11 erase wr_en low", 8'h77, 4'h3, 0, 0, 1, 0, 1);
    cyc("R11 lone erase 2", 8'h77, 4'h3, 1, 0, 1, 0, 1);
    cyc("R11 absent", 8'h77, 0, 0, 0, 0, 1, 1);
    check("R11 zero", 16'h0000);
    cyc("R11 entry 2 intact", 8'hFF, 0, 0, 0, 0, 1, 1);
    check("R11 bit 2", 16'h0004);
    // random phase, small key pool to force multi-matches and overwrites
    for (int n = 0; n < 600; n++) begin
      automatic int op = $urandom_range(0, 9);
      automatic logic [7:0] k = {6'd0, 2'($urandom_range(0, 3))} ^ 8'hA0;
      automatic logic [3:0] a = 4'($urandom_range(0, 15));
      automatic logic se = 1'($urandom_range(0, 1));
      if (op < 4)       write("R6 rnd write", k, a, 8'($urandom), se);
      else if (op < 8)  cyc("R2 rnd search", k, 0, 0, 0, 0, 1, 1);
      else if (op == 8) cyc("R8 rnd idle", k, a, 0, 0, 0, 0, 1);
      else              cyc("R9 rnd clear", k, a, 0, 0, 0, se, 0);
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule